// File: doc/BRIEF.md
# Five-State Snooping Coherence Controller

This block keeps the coherence state of a small table of cache lines for one core on a single shared snooping bus. It supports five states: Invalid, Shared, Exclusive, Forwarding and Modified. Forwarding marks the reader that requested the line most recently. That reader answers the next snooped read miss by sending the line straight to the requester, and the requester then takes over the forwarding role. The controller reacts to two local events, a CPU read and a CPU write. It also reacts to two snooped events, a bus read miss and a bus write miss, sent by other cores.

Every output is combinational from the current inputs and the stored state. The table is updated on the next rising clock edge. A local miss drives a bus request for the requested line. The `shared_resp` wire tells the controller whether another cache holds the line, and it is sampled during that same cycle. A snooped event can raise data forwarding, a writeback indication, or both, and it reports whether this core holds the snooped line. A lookup port returns the stored state of any line. Only one event is applied per cycle. When a snoop and a local request arrive together, the snoop wins.

Top module: `mesif_coherence_ctrl`

## Requirements
- R1: After reset every line reads Invalid on `look_state`. The state codes are Invalid=0, Shared=1, Exclusive=2, Forwarding=3, Modified=4, and no other code ever appears.
- R2: A CPU read of an Invalid line raises `bus_req_valid` with `bus_req_write`=0 and `bus_req_line` equal to the requested line, in the same cycle. After the clock edge the line is Forwarding if `shared_resp` was 1, and Exclusive if it was 0.
- R3: A CPU write of an Exclusive line makes no bus request, and the line becomes Modified.
- R4: A CPU write of an Invalid, Shared or Forwarding line raises `bus_req_valid` with `bus_req_write`=1, and the line becomes Modified. A CPU write of a Modified line makes no bus request and leaves the line Modified.
- R5: A CPU read of a line in any valid state makes no bus request and leaves the state unchanged. `cpu_hit` is 1 exactly when the requested line is not Invalid.
- R6: A snooped read miss on a Forwarding line raises `fwd_valid` without `wb_valid`, and the line becomes Shared.
- R7: A snooped read miss on a Modified line raises both `wb_valid` and `fwd_valid`, and the line becomes Shared. On an Exclusive line the line becomes Shared with neither output raised. On a Shared or Invalid line there is no output and no change.
- R8: A snooped write miss moves the line to Invalid. `wb_valid` is raised only if the line was Modified, and `fwd_valid` stays 0.
- R9: `snoop_hit` is 1 exactly when the snooped line is not Invalid.
- R10: While `snoop_valid` is 1, a concurrent CPU request is dropped. No bus request is raised and the requested line keeps its state.
- R11: When several controllers share the bus, then after every transaction there is at most one Modified copy of any line and at most one Forwarding copy, and a Modified copy never coexists with any other valid copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Local CPU access this cycle |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_line | input | IDX_W | Line index of the local access |
| shared_resp | input | 1 | Another cache holds the missed line |
| snoop_valid | input | 1 | Snooped bus miss from another core |
| snoop_write | input | 1 | 1 = write miss, 0 = read miss |
| snoop_line | input | IDX_W | Line index of the snooped miss |
| bus_req_valid | output | 1 | Drive a miss onto the bus |
| bus_req_write | output | 1 | 1 = write miss, 0 = read miss |
| bus_req_line | output | IDX_W | Line of the bus miss |
| fwd_valid | output | 1 | Supply the line directly to the requester |
| wb_valid | output | 1 | Write the dirty line back |
| snoop_hit | output | 1 | This core holds the snooped line |
| cpu_hit | output | 1 | This core holds the requested line |
| look_line | input | IDX_W | Line to inspect |
| look_state | output | 3 | State code of `look_line` |

## Verification
The hardest case to reach is the Forwarding handoff chain. A line has to pass from Exclusive to Forwarding across three cores while a Modified owner is demoted, and each step is only reachable after a particular history of reads and writes from other cores. The bench therefore runs three controllers on a modelled bus with only four lines, so that random accesses collide on the same lines constantly. A directed opening walks one line through every transition of the chain. The rare case of a snoop arriving together with a local request is injected on purpose at random points.

// File: rtl/mesif_pkg.sv
package mesif_pkg;

   localparam int ST_W = 3;

   typedef enum logic [ST_W-1:0] {
      ST_I = 3'd0,
      ST_S = 3'd1,
      ST_E = 3'd2,
      ST_F = 3'd3,
      ST_M = 3'd4
   } mesif_st_t;

   typedef struct packed {
      mesif_st_t nxt;
      logic      bus_req;
      logic      bus_wr;
   } cpu_act_t;

   typedef struct packed {
      mesif_st_t nxt;
      logic      fwd;
      logic      wb;
   } snp_act_t;

endpackage

// File: rtl/mesif_cpu_fsm.sv
module mesif_cpu_fsm
   import mesif_pkg::*;
(
   input  mesif_st_t cur,
   input  logic      is_write,
   input  logic      others_hold,
   output cpu_act_t  act
);
   always_comb begin
      act     = '0;
      act.nxt = cur;
      if (is_write) begin
         case (cur)
            ST_M: act.nxt = ST_M;
            ST_E: act.nxt = ST_M;
            default: begin
               act.bus_req = 1'b1;
               act.bus_wr  = 1'b1;
               act.nxt     = ST_M;
            end
         endcase
      end else if (cur == ST_I) begin
         act.bus_req = 1'b1;
         act.nxt     = others_hold ? ST_F : ST_E;
      end
   end
endmodule

// File: rtl/mesif_snoop_fsm.sv
module mesif_snoop_fsm
   import mesif_pkg::*;
(
   input  mesif_st_t cur,
   input  logic      is_write,
   output snp_act_t  act
);
   always_comb begin
      act     = '0;
      act.nxt = cur;
      if (is_write) begin
         act.wb  = (cur == ST_M);
         act.nxt = ST_I;
      end else begin
         case (cur)
            ST_M: begin
               act.wb  = 1'b1;
               act.fwd = 1'b1;
               act.nxt = ST_S;
            end
            ST_E: act.nxt = ST_S;
            ST_F: begin
               act.fwd = 1'b1;
               act.nxt = ST_S;
            end
            default: act.nxt = cur;
         endcase
      end
   end
endmodule

// File: rtl/mesif_line_table.sv
module mesif_line_table
   import mesif_pkg::*;
#(
   parameter int NUM_LINES = 8,
   parameter int IDX_W     = $clog2(NUM_LINES)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             upd_en,
   input  logic [IDX_W-1:0]                 upd_line,
   input  mesif_st_t                        upd_st,
   output logic [NUM_LINES-1:0][ST_W-1:0]   st_vec
);
   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_vec[l] <= ST_I;
         end else if (upd_en && (upd_line == IDX_W'(l))) begin
            st_vec[l] <= upd_st;
         end
      end
   end
endmodule

// File: rtl/mesif_coherence_ctrl.sv
module mesif_coherence_ctrl
   import mesif_pkg::*;
#(
   parameter int   NUM_LINES = 8,
   localparam int  IDX_W     = $clog2(NUM_LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_req_valid,
   input  logic             cpu_req_write,
   input  logic [IDX_W-1:0] cpu_req_line,
   input  logic             shared_resp,
   input  logic             snoop_valid,
   input  logic             snoop_write,
   input  logic [IDX_W-1:0] snoop_line,
   output logic             bus_req_valid,
   output logic             bus_req_write,
   output logic [IDX_W-1:0] bus_req_line,
   output logic             fwd_valid,
   output logic             wb_valid,
   output logic             snoop_hit,
   output logic             cpu_hit,
   input  logic [IDX_W-1:0] look_line,
   output logic [ST_W-1:0]  look_state
);
   if (NUM_LINES < 2 || (NUM_LINES & (NUM_LINES - 1)) != 0) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end

   logic [NUM_LINES-1:0][ST_W-1:0] st_vec;
   mesif_st_t cpu_cur, snp_cur, upd_st;
   cpu_act_t  cpu_act;
   snp_act_t  snp_act;
   logic      cpu_go, upd_en;
   logic [IDX_W-1:0] upd_line;

   assign cpu_cur = mesif_st_t'(st_vec[cpu_req_line]);
   assign snp_cur = mesif_st_t'(st_vec[snoop_line]);

   mesif_cpu_fsm cpu_fsm_i (
      .cur         (cpu_cur),
      .is_write    (cpu_req_write),
      .others_hold (shared_resp),
      .act         (cpu_act)
   );

   mesif_snoop_fsm snp_fsm_i (
      .cur      (snp_cur),
      .is_write (snoop_write),
      .act      (snp_act)
   );

   assign cpu_go        = cpu_req_valid & ~snoop_valid;
   assign bus_req_valid = cpu_go & cpu_act.bus_req;
   assign bus_req_write = cpu_act.bus_wr;
   assign bus_req_line  = cpu_req_line;
   assign fwd_valid     = snoop_valid & snp_act.fwd;
   assign wb_valid      = snoop_valid & snp_act.wb;
   assign snoop_hit     = (snp_cur != ST_I);
   assign cpu_hit       = (cpu_cur != ST_I);
   assign look_state    = st_vec[look_line];

   assign upd_en   = snoop_valid | cpu_go;
   assign upd_line = snoop_valid ? snoop_line : cpu_req_line;
   assign upd_st   = snoop_valid ? snp_act.nxt : cpu_act.nxt;

   mesif_line_table #(
      .NUM_LINES (NUM_LINES),
      .IDX_W     (IDX_W)
   ) table_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_en   (upd_en),
      .upd_line (upd_line),
      .upd_st   (upd_st),
      .st_vec   (st_vec)
   );
endmodule

// File: rtl/mesif_coherence_chk.sv
module mesif_coherence_chk #(
   parameter int NUM_LINES = 8,
   parameter int IDX_W     = 3
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          cpu_req_valid,
   input logic                          cpu_req_write,
   input logic [IDX_W-1:0]              cpu_req_line,
   input logic                          snoop_valid,
   input logic                          snoop_write,
   input logic [IDX_W-1:0]              snoop_line,
   input logic                          bus_req_valid,
   input logic                          bus_req_write,
   input logic                          fwd_valid,
   input logic                          wb_valid,
   input logic [NUM_LINES-1:0][2:0]     st_vec
);
   for (genvar l = 0; l < NUM_LINES; l++) begin : g_legal
      p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
         st_vec[l] <= 3'd4);
   end

   p_read_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_valid && !cpu_req_write && !snoop_valid && st_vec[cpu_req_line] == 3'd0)
      |-> (bus_req_valid && !bus_req_write));

   p_excl_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_valid && cpu_req_write && !snoop_valid && st_vec[cpu_req_line] == 3'd2)
      |-> !bus_req_valid);

   p_excl_to_mod_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_valid && cpu_req_write && !snoop_valid && st_vec[cpu_req_line] == 3'd2)
      |=> st_vec[$past(cpu_req_line)] == 3'd4);

   p_write_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_valid && cpu_req_write && !snoop_valid &&
       (st_vec[cpu_req_line] == 3'd0 || st_vec[cpu_req_line] == 3'd1 ||
        st_vec[cpu_req_line] == 3'd3))
      |-> (bus_req_valid && bus_req_write));

   p_hit_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_valid && !cpu_req_write && st_vec[cpu_req_line] != 3'd0)
      |-> !bus_req_valid);

   p_fwd_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_valid && !snoop_write && st_vec[snoop_line] == 3'd3)
      |-> (fwd_valid && !wb_valid));

   p_fwd_handoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_valid && !snoop_write && st_vec[snoop_line] == 3'd3)
      |=> st_vec[$past(snoop_line)] == 3'd1);

   p_wb_only_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (snoop_valid && st_vec[snoop_line] == 3'd4));

   p_snoop_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
      snoop_valid |-> !bus_req_valid);
endmodule

bind mesif_coherence_ctrl mesif_coherence_chk #(
   .NUM_LINES (NUM_LINES),
   .IDX_W     (IDX_W)
) chk_i (.*);

// File: tb/mesif_coherence_ctrl_tb_top.sv
`timescale 1ns/100ps
module mesif_coherence_ctrl_tb_top;
   localparam int NC = 3;
   localparam int NL = 4;
   localparam int IW = 2;
   localparam int SI = 0, SS = 1, SE = 2, SF = 3, SM = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [NC-1:0]         cpu_v, cpu_w, shr, sv, sw;
   logic [NC-1:0][IW-1:0] cpu_l, sl, look_l;
   logic [NC-1:0]         brv, brw, fwd, wb, shit, chit;
   logic [NC-1:0][IW-1:0] brl;
   logic [NC-1:0][2:0]    lst;

   for (genvar c = 0; c < NC; c++) begin : g_core
      mesif_coherence_ctrl #(.NUM_LINES(NL)) dut_i (
         .clk(clk), .rst_n(rst_n),
         .cpu_req_valid(cpu_v[c]), .cpu_req_write(cpu_w[c]), .cpu_req_line(cpu_l[c]),
         .shared_resp(shr[c]),
         .snoop_valid(sv[c]), .snoop_write(sw[c]), .snoop_line(sl[c]),
         .bus_req_valid(brv[c]), .bus_req_write(brw[c]), .bus_req_line(brl[c]),
         .fwd_valid(fwd[c]), .wb_valid(wb[c]),
         .snoop_hit(shit[c]), .cpu_hit(chit[c]),
         .look_line(look_l[c]), .look_state(lst[c])
      );
   end

   int n_checks = 0;
   int n_fail   = 0;
   int exp_st [NC][NL];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   function automatic int snp_next(input int cur, input bit wr);
      if (wr) return SI;
      if (cur == SM || cur == SE || cur == SF) return SS;
      return cur;
   endfunction
   function automatic bit snp_fwd(input int cur, input bit wr);
      return !wr && (cur == SM || cur == SF);
   endfunction
   function automatic bit snp_wb(input int cur);
      return cur == SM;
   endfunction
   function automatic string snp_tag(input int cur, input bit wr);
      if (wr) return "R8";
      if (cur == SF) return "R6";
      return "R7";
   endfunction

   task automatic idle();
      cpu_v = '0; cpu_w = '0; cpu_l = '0; shr = '0;
      sv = '0; sw = '0; sl = '0;
   endtask

   task automatic sweep(input string tag);
      int nm, nf, nv;
      for (int l = 0; l < NL; l++) begin
         for (int c = 0; c < NC; c++) look_l[c] = IW'(l);
         #0.1;
         nm = 0; nf = 0; nv = 0;
         for (int c = 0; c < NC; c++) begin
            chk(int'(lst[c]) == exp_st[c][l], tag, $sformatf("state core%0d line%0d", c, l),
                int'(lst[c]), exp_st[c][l]);
            if (lst[c] == 3'd4) nm++;
            if (lst[c] == 3'd3) nf++;
            if (lst[c] != 3'd0) nv++;
         end
         chk(nm <= 1 && nf <= 1 && !(nm == 1 && nv > 1), "R11",
             $sformatf("invariant line%0d M/F/valid", l), nm * 100 + nf * 10 + nv, 0);
      end
   endtask

   task automatic do_op(input int k, input bit wr, input int line);
      int  cur;
      bit  shared, need_bus;
      string tag;
      int  pre [NC];
      @(negedge clk);
      cur = exp_st[k][line];
      shared = 1'b0;
      for (int j = 0; j < NC; j++) begin
         pre[j] = exp_st[j][line];
         if (j != k && exp_st[j][line] != SI) shared = 1'b1;
      end
      if (wr) begin
         need_bus = (cur == SI || cur == SS || cur == SF);
         tag = (cur == SE) ? "R3" : "R4";
      end else begin
         need_bus = (cur == SI);
         tag = need_bus ? "R2" : "R5";
      end
      cpu_v[k] = 1'b1; cpu_w[k] = wr; cpu_l[k] = IW'(line); shr[k] = shared;
      if (need_bus) begin
         for (int j = 0; j < NC; j++) begin
            if (j != k) begin sv[j] = 1'b1; sw[j] = wr; sl[j] = IW'(line); end
         end
      end
      #1;
      chk(brv[k] == need_bus, tag, "bus_req_valid", int'(brv[k]), int'(need_bus));
      if (need_bus) begin
         chk(brw[k] == wr, tag, "bus_req_write", int'(brw[k]), int'(wr));
         chk(int'(brl[k]) == line, tag, "bus_req_line", int'(brl[k]), line);
      end
      chk(chit[k] == (cur != SI), "R5", "cpu_hit", int'(chit[k]), int'(cur != SI));
      for (int j = 0; j < NC; j++) begin
         if (j != k && need_bus) begin
            chk(fwd[j] == snp_fwd(pre[j], wr), snp_tag(pre[j], wr), $sformatf("fwd core%0d", j),
                int'(fwd[j]), int'(snp_fwd(pre[j], wr)));
            chk(wb[j] == snp_wb(pre[j]), snp_tag(pre[j], wr), $sformatf("wb core%0d", j),
                int'(wb[j]), int'(snp_wb(pre[j])));
            chk(shit[j] == (pre[j] != SI), "R9", $sformatf("snoop_hit core%0d", j),
                int'(shit[j]), int'(pre[j] != SI));
         end
      end
      @(posedge clk);
      #0.5;
      idle();
      if (need_bus)
         for (int j = 0; j < NC; j++) if (j != k) exp_st[j][line] = snp_next(pre[j], wr);
      if (wr) exp_st[k][line] = SM;
      else if (cur == SI) exp_st[k][line] = shared ? SF : SE;
      sweep(tag);
   endtask

   task automatic do_prio(input int k, input int line, input bit swr);
      int b, curb;
      b = (line + 1) % NL;
      @(negedge clk);
      curb = exp_st[k][b];
      cpu_v[k] = 1'b1; cpu_w[k] = $urandom_range(0, 1); cpu_l[k] = IW'(line);
      sv[k] = 1'b1; sw[k] = swr; sl[k] = IW'(b);
      #1;
      chk(brv[k] == 1'b0, "R10", "bus_req_valid under snoop", int'(brv[k]), 0);
      chk(wb[k] == snp_wb(curb) && !(swr == 0 && curb == SI && fwd[k]), snp_tag(curb, swr),
          "snoop outputs on own core", int'(wb[k]), int'(snp_wb(curb)));
      @(posedge clk);
      #0.5;
      idle();
      exp_st[k][b] = snp_next(curb, swr);
      sweep("R10");
   endtask

   initial begin
      #100000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      idle();
      look_l = '0;
      for (int c = 0; c < NC; c++) for (int l = 0; l < NL; l++) exp_st[c][l] = SI;
      repeat (3) @(posedge clk);
      #0.5 rst_n = 1'b1;
      sweep("R1");

      // directed forwarding chain on line 0
      do_op(0, 1'b0, 0);   // R2: I -> E
      do_op(0, 1'b1, 0);   // R3: E -> M silently
      do_op(1, 1'b0, 0);   // R7: M snooped read -> S with wb+fwd, R2 -> F
      do_op(2, 1'b0, 0);   // R6: F hands off to core 2
      do_op(0, 1'b1, 0);   // R4: S -> M write miss, R8 invalidates others
      do_op(1, 1'b1, 0);   // R8: dirty owner writes back
      do_op(1, 1'b1, 0);   // R4: M write stays quiet
      do_op(1, 1'b0, 0);   // R5: read hit
      do_op(2, 1'b0, 1);
      do_op(2, 1'b1, 1);   // R3 again on a fresh line
      do_prio(0, 2, 1'b0); // R10
      do_prio(2, 0, 1'b1); // R10 with write snoop on a dirty line

      for (int i = 0; i < 1500; i++) begin
         if ($urandom_range(0, 15) == 0)
            do_prio($urandom_range(0, NC - 1), $urandom_range(0, NL - 1), 1'($urandom_range(0, 1)));
         else
            do_op($urandom_range(0, NC - 1), ($urandom_range(0, 2) == 0),
                  $urandom_range(0, NL - 1));
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule